// File: doc/BRIEF.md
# Variable-Range Address Translation Buffer

This block is a small fully associative translation buffer. Every entry maps a contiguous virtual range onto a physical range. An entry's size is a 4 KB base page multiplied by a power of four. A parameter sets aside the lowest-numbered slots as block slots. Firmware fills these slots directly with an explicit slot index and an arbitrary page count, and ordinary purges leave them in place. All other slots are filled by a two-word insert command and are replaced through a free-slot scan, with a round-robin fallback.

Lookups can be issued on any cycle. Each returns, one cycle later, a hit flag, the translated physical address and the stored attribute bits. Purges act on every slot in the same cycle. Inserts take two cycles: in the first, every overlapping ordinary entry is invalidated; in the second, a slot is allocated and written. Permission evaluation belongs to the consumer of the attribute bits.

The controller has three states:
- `S_IDLE` accepts commands.
- `S_INS_WRITE` writes an ordinary entry.
- `S_BLK_WRITE` writes a block slot.

The transitions are:
- `S_IDLE` to `S_INS_WRITE` when an insert is accepted.
- `S_IDLE` to `S_BLK_WRITE` when a well-formed block insert is accepted.
- Both write states return to `S_IDLE` after one cycle.

Top module: `range_tlb`

## Requirements
- R1: A lookup asserted at clock edge k gives `lk_rsp_valid` after edge k. `lk_hit` is 1 when some valid slot has start ≤ VA ≤ last. On a hit, `lk_pa` = entry physical base + (VA − start), truncated to PA_W bits. On a miss, `lk_pa` and `lk_attr` are zero.
- R2: The insert size code is `ins_op1[3:0]` = c. The entry covers 4096·4^c bytes, and its start is `ins_va` aligned down to that size.
- R3: The physical base is `ins_op1` shifted left by 7, so that bit 5 lands on bit 12. It is then aligned down to the entry size and truncated to PA_W bits.
- R4: The attributes are taken from `ins_op2` as follows:
  - T = bit 61, D = bit 60, B = bit 59;
  - type = bits 58:56;
  - level one = bits 55:54, level two = bits 53:52;
  - U = bit 51;
  - id = bits 31:1.
  `lk_attr` packs them, from MSB down, as {T, D, B, type[2:0], level one[1:0], level two[1:0], U, id[30:0]}, which is 42 bits. All other operand bits are ignored.
- R5: In the cycle an insert is accepted, every valid ordinary slot whose range overlaps the new range is invalidated before the new entry is written.
- R6: The insert writes the lowest-index invalid ordinary slot. When there is none, it writes the slot under a round-robin pointer. That pointer starts at the first ordinary slot, advances only when it is used, and wraps from the last slot back to the first ordinary slot.
- R7: A range purge covers `pur_addr` aligned down to 4096·4^c, where c = `pur_addr[3:0]`; a code of zero means one page. Overlapping ordinary slots are invalidated, and block slots are kept.
- R8: Purge-all invalidates every ordinary slot, keeps the block slots and returns the round-robin pointer to the first ordinary slot.
- R9: A block insert is rejected when `blk_slot` ≥ N_BLOCK or `blk_len` = 0. A rejected block insert raises `blk_err` after its edge and changes nothing. An accepted one writes the range `blk_vpage`·4096 to (`blk_vpage`+`blk_len`)·4096−1, with physical base `blk_ppage`·4096 and the R4 fields of `blk_word`, except that T is forced to 0 and D to 1.
- R10: A block purge with `blk_slot` ≥ N_BLOCK raises `blk_err` and changes nothing; otherwise it invalidates that slot.
- R11: When several valid slots contain the lookup address, the lowest-index slot supplies the result.
- R12: A lookup in the same cycle as a purge sees the table as it was before that purge.
- R13: `busy` is high for exactly the one cycle after an accepted insert or block insert, and every command in that cycle is ignored. When commands coincide in `S_IDLE`, one is taken, in this order: purge-all, block purge, block insert, insert, range purge. The others are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup strobe |
| lk_va | input | VA_W | Lookup virtual address |
| lk_rsp_valid | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | PA_W | Translated physical address |
| lk_attr | output | 42 | Packed attributes of the hit entry |
| ins_req | input | 1 | Ordinary insert strobe |
| ins_op1 | input | 64 | Physical page word with size code |
| ins_op2 | input | 64 | Attribute word |
| ins_va | input | VA_W | Virtual base of the insert |
| pur_req | input | 1 | Range purge strobe |
| pur_addr | input | VA_W | Page address with size code in bits 3:0 |
| purall_req | input | 1 | Purge-all strobe |
| blk_ins_req | input | 1 | Block insert strobe |
| blk_pur_req | input | 1 | Block purge strobe |
| blk_slot | input | SLOT_W | Block slot index |
| blk_vpage | input | VA_W-12 | Block virtual page number |
| blk_ppage | input | PA_W-12 | Block physical page number |
| blk_len | input | LEN_W | Block length in pages |
| blk_word | input | 64 | Block attribute word |
| blk_err | output | 1 | Invalid-argument pulse for block commands |
| busy | output | 1 | Controller in a write state |

## Verification
The assertions check the following on every cycle:
- every lookup is answered on the next cycle, and a hit never appears without a response;
- `busy` never lasts beyond one cycle, and an accepted insert always raises it;
- `blk_err` appears only after a block command and never together with `busy`;
- the round-robin pointer stays within the ordinary slots.

Only the bench scenarios can show the rest:
- the address arithmetic, meaning size codes, alignment of both bases and offsets;
- which entries an insert or purge removes, and the survival of block slots;
- the free-slot-first and round-robin replacement order;
- lowest-index priority;
- the pre-purge view seen by a coinciding lookup.

// File: rtl/rtlb_pkg.sv
`timescale 1ns/1ps
package rtlb_pkg;

    typedef enum logic [1:0] {
        S_IDLE      = 2'd0,
        S_INS_WRITE = 2'd1,
        S_BLK_WRITE = 2'd2
    } ctl_state_t;

    typedef struct packed {
        logic        t;
        logic        d;
        logic        b;
        logic [2:0]  ar_type;
        logic [1:0]  lvl_one;
        logic [1:0]  lvl_two;
        logic        u;
        logic [30:0] aid;
    } attr_t;

    localparam int ATTR_W = $bits(attr_t);

    function automatic attr_t attr_from_word(input logic [63:0] w);
        attr_t a;
        a.t       = w[61];
        a.d       = w[60];
        a.b       = w[59];
        a.ar_type = w[58:56];
        a.lvl_one = w[55:54];
        a.lvl_two = w[53:52];
        a.u       = w[51];
        a.aid     = w[31:1];
        return a;
    endfunction

endpackage

// File: rtl/rtlb_span.sv
`timescale 1ns/1ps
// Turns an address and a power-of-four size code into an aligned range.
module rtlb_span #(
    parameter int VA_W      = 48,
    parameter int PAGE_BITS = 12
) (
    input  logic [VA_W-1:0] addr_i,
    input  logic [3:0]      code_i,
    output logic [VA_W-1:0] base_o,
    output logic [VA_W-1:0] last_o,
    output logic [VA_W-1:0] low_mask_o
);
    localparam logic [VA_W-1:0] ONE = {{(VA_W-1){1'b0}}, 1'b1};

    int shamt;

    always_comb begin
        shamt      = PAGE_BITS + 2 * int'(code_i);
        low_mask_o = (ONE << shamt) - ONE;
        base_o     = addr_i & ~low_mask_o;
        last_o     = base_o | low_mask_o;
    end
endmodule

// File: rtl/rtlb_overlap.sv
`timescale 1ns/1ps
// Flags every valid slot whose range intersects [lo, hi].
module rtlb_overlap #(
    parameter int N_SLOTS = 8,
    parameter int VA_W    = 48
) (
    input  logic [N_SLOTS-1:0] valid_i,
    input  logic [VA_W-1:0]    start_i [N_SLOTS],
    input  logic [VA_W-1:0]    last_i  [N_SLOTS],
    input  logic [VA_W-1:0]    lo_i,
    input  logic [VA_W-1:0]    hi_i,
    output logic [N_SLOTS-1:0] ovl_o
);
    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        assign ovl_o[g] = valid_i[g] && (start_i[g] <= hi_i) && (lo_i <= last_i[g]);
    end
endmodule

// File: rtl/rtlb_match.sv
`timescale 1ns/1ps
// Containment compare on all slots, lowest index wins.
module rtlb_match #(
    parameter int N_SLOTS = 8,
    parameter int VA_W    = 48,
    localparam int SLOT_W = $clog2(N_SLOTS)
) (
    input  logic [N_SLOTS-1:0] valid_i,
    input  logic [VA_W-1:0]    start_i [N_SLOTS],
    input  logic [VA_W-1:0]    last_i  [N_SLOTS],
    input  logic [VA_W-1:0]    va_i,
    output logic               hit_o,
    output logic [SLOT_W-1:0]  idx_o
);
    logic [N_SLOTS-1:0] in_range;

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_cmp
        assign in_range[g] = valid_i[g] && (start_i[g] <= va_i) && (va_i <= last_i[g]);
    end

    always_comb begin
        hit_o = |in_range;
        idx_o = '0;
        for (int i = N_SLOTS - 1; i >= 0; i--) begin
            if (in_range[i]) idx_o = SLOT_W'(i);
        end
    end
endmodule

// File: rtl/rtlb_alloc.sv
`timescale 1ns/1ps
// Victim choice: lowest invalid ordinary slot, else the round-robin slot.
module rtlb_alloc #(
    parameter int N_SLOTS = 8,
    parameter int N_BLOCK = 2,
    localparam int SLOT_W = $clog2(N_SLOTS)
) (
    input  logic [N_SLOTS-1:0] valid_i,
    input  logic [SLOT_W-1:0]  rr_i,
    output logic [SLOT_W-1:0]  slot_o,
    output logic               free_o
);
    always_comb begin
        free_o = 1'b0;
        slot_o = rr_i;
        for (int i = N_SLOTS - 1; i >= N_BLOCK; i--) begin
            if (!valid_i[i]) begin
                free_o = 1'b1;
                slot_o = SLOT_W'(i);
            end
        end
    end
endmodule

// File: rtl/range_tlb.sv
`timescale 1ns/1ps
module range_tlb
    import rtlb_pkg::*;
#(
    parameter int N_SLOTS   = 8,
    parameter int N_BLOCK   = 2,
    parameter int VA_W      = 48,
    parameter int PA_W      = 40,
    parameter int PAGE_BITS = 12,
    parameter int LEN_W     = 16,
    localparam int SLOT_W   = $clog2(N_SLOTS),
    localparam int VPN_W    = VA_W - PAGE_BITS,
    localparam int PPN_W    = PA_W - PAGE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [VA_W-1:0]   lk_va,
    output logic              lk_rsp_valid,
    output logic              lk_hit,
    output logic [PA_W-1:0]   lk_pa,
    output logic [ATTR_W-1:0] lk_attr,
    input  logic              ins_req,
    input  logic [63:0]       ins_op1,
    input  logic [63:0]       ins_op2,
    input  logic [VA_W-1:0]   ins_va,
    input  logic              pur_req,
    input  logic [VA_W-1:0]   pur_addr,
    input  logic              purall_req,
    input  logic              blk_ins_req,
    input  logic              blk_pur_req,
    input  logic [SLOT_W-1:0] blk_slot,
    input  logic [VPN_W-1:0]  blk_vpage,
    input  logic [PPN_W-1:0]  blk_ppage,
    input  logic [LEN_W-1:0]  blk_len,
    input  logic [63:0]       blk_word,
    output logic              blk_err,
    output logic              busy
);
    localparam logic [N_SLOTS-1:0] BLOCK_MASK = N_SLOTS'((64'd1 << N_BLOCK) - 64'd1);
    localparam logic [SLOT_W-1:0]  FIRST_ORD  = SLOT_W'(N_BLOCK);
    localparam int                 PA_SHIFT   = PAGE_BITS - 5;

    // ---------------- state ----------------
    ctl_state_t state_q, state_d;

    logic [N_SLOTS-1:0] ent_v;
    logic [VA_W-1:0]    ent_start [N_SLOTS];
    logic [VA_W-1:0]    ent_last  [N_SLOTS];
    logic [PA_W-1:0]    ent_pa    [N_SLOTS];
    attr_t              ent_attr  [N_SLOTS];
    logic [SLOT_W-1:0]  rr_q;

    logic [VA_W-1:0]    pend_start, pend_last;
    logic [PA_W-1:0]    pend_pa;
    attr_t              pend_attr;
    logic [SLOT_W-1:0]  pend_slot;

    // ---------------- command decode ----------------
    logic idle;
    logic do_all, do_bpur, do_bins, do_ins, do_pur;
    logic slot_bad, bins_bad;

    always_comb begin
        idle     = (state_q == S_IDLE);
        do_all   = idle && purall_req;
        do_bpur  = idle && !purall_req && blk_pur_req;
        do_bins  = idle && !purall_req && !blk_pur_req && blk_ins_req;
        do_ins   = idle && !purall_req && !blk_pur_req && !blk_ins_req && ins_req;
        do_pur   = idle && !purall_req && !blk_pur_req && !blk_ins_req && !ins_req && pur_req;
        slot_bad = int'(blk_slot) >= N_BLOCK;
        bins_bad = slot_bad || (blk_len == '0);
    end

    // ---------------- insert range and physical base ----------------
    logic [VA_W-1:0] ins_base, ins_last, ins_low;
    logic [63:0]     op1_sh;
    logic [PA_W-1:0] ins_pa;

    rtlb_span #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS)) u_ins_span (
        .addr_i    (ins_va),
        .code_i    (ins_op1[3:0]),
        .base_o    (ins_base),
        .last_o    (ins_last),
        .low_mask_o(ins_low)
    );

    always_comb begin
        op1_sh = ins_op1 << PA_SHIFT;
        ins_pa = op1_sh[PA_W-1:0] & ~ins_low[PA_W-1:0];
    end

    // ---------------- purge range ----------------
    logic [VA_W-1:0] pur_base, pur_last, pur_low;

    rtlb_span #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS)) u_pur_span (
        .addr_i    (pur_addr),
        .code_i    (pur_addr[3:0]),
        .base_o    (pur_base),
        .last_o    (pur_last),
        .low_mask_o(pur_low)
    );

    // ---------------- block entry image ----------------
    logic [VA_W-1:0] blk_start, blk_last;
    logic [PA_W-1:0] blk_pa;
    attr_t           blk_attr;

    always_comb begin
        blk_start  = {blk_vpage, {PAGE_BITS{1'b0}}};
        blk_last   = blk_start + (VA_W'(blk_len) << PAGE_BITS) - VA_W'(1);
        blk_pa     = {blk_ppage, {PAGE_BITS{1'b0}}};
        blk_attr   = attr_from_word(blk_word);
        blk_attr.t = 1'b0;
        blk_attr.d = 1'b1;
    end

    // ---------------- overlap kill vector ----------------
    logic [VA_W-1:0]    ovl_lo, ovl_hi;
    logic [N_SLOTS-1:0] ovl, kill;

    assign ovl_lo = do_ins ? ins_base : pur_base;
    assign ovl_hi = do_ins ? ins_last : pur_last;

    rtlb_overlap #(.N_SLOTS(N_SLOTS), .VA_W(VA_W)) u_ovl (
        .valid_i(ent_v),
        .start_i(ent_start),
        .last_i (ent_last),
        .lo_i   (ovl_lo),
        .hi_i   (ovl_hi),
        .ovl_o  (ovl)
    );

    assign kill = ovl & ~BLOCK_MASK;

    // ---------------- allocation ----------------
    logic [SLOT_W-1:0] alloc_slot;
    logic              alloc_free;

    rtlb_alloc #(.N_SLOTS(N_SLOTS), .N_BLOCK(N_BLOCK)) u_alloc (
        .valid_i(ent_v),
        .rr_i   (rr_q),
        .slot_o (alloc_slot),
        .free_o (alloc_free)
    );

    // ---------------- lookup compare ----------------
    logic              m_hit;
    logic [SLOT_W-1:0] m_idx;
    logic [VA_W-1:0]   m_off;

    rtlb_match #(.N_SLOTS(N_SLOTS), .VA_W(VA_W)) u_match (
        .valid_i(ent_v),
        .start_i(ent_start),
        .last_i (ent_last),
        .va_i   (lk_va),
        .hit_o  (m_hit),
        .idx_o  (m_idx)
    );

    assign m_off = lk_va - ent_start[m_idx];

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (do_ins)                    state_d = S_INS_WRITE;
                else if (do_bins && !bins_bad) state_d = S_BLK_WRITE;
            end
            S_INS_WRITE: state_d = S_IDLE;
            S_BLK_WRITE: state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- valid bits and round-robin pointer ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_v <= '0;
            rr_q  <= FIRST_ORD;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (do_all) begin
                        ent_v <= ent_v & BLOCK_MASK;
                        rr_q  <= FIRST_ORD;
                    end else if ((do_bpur && !slot_bad) || (do_bins && !bins_bad)) begin
                        ent_v[blk_slot] <= 1'b0;
                    end else if (do_ins || do_pur) begin
                        ent_v <= ent_v & ~kill;
                    end
                end
                S_INS_WRITE: begin
                    ent_v[alloc_slot] <= 1'b1;
                    if (!alloc_free) begin
                        rr_q <= (int'(rr_q) == N_SLOTS - 1) ? FIRST_ORD : rr_q + 1'b1;
                    end
                end
                S_BLK_WRITE: ent_v[pend_slot] <= 1'b1;
                default: ;
            endcase
        end
    end

    // ---------------- pending entry latch ----------------
    always_ff @(posedge clk) begin
        if (do_ins) begin
            pend_start <= ins_base;
            pend_last  <= ins_last;
            pend_pa    <= ins_pa;
            pend_attr  <= attr_from_word(ins_op2);
        end else if (do_bins) begin
            pend_start <= blk_start;
            pend_last  <= blk_last;
            pend_pa    <= blk_pa;
            pend_attr  <= blk_attr;
            pend_slot  <= blk_slot;
        end
    end

    // ---------------- entry payload ----------------
    logic              wr_en;
    logic [SLOT_W-1:0] wr_slot;

    assign wr_en   = (state_q == S_INS_WRITE) || (state_q == S_BLK_WRITE);
    assign wr_slot = (state_q == S_INS_WRITE) ? alloc_slot : pend_slot;

    always_ff @(posedge clk) begin
        for (int i = 0; i < N_SLOTS; i++) begin
            if (wr_en && (int'(wr_slot) == i)) begin
                ent_start[i] <= pend_start;
                ent_last[i]  <= pend_last;
                ent_pa[i]    <= pend_pa;
                ent_attr[i]  <= pend_attr;
            end
        end
    end

    // ---------------- registered outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_rsp_valid <= 1'b0;
            lk_hit       <= 1'b0;
            lk_pa        <= '0;
            lk_attr      <= '0;
            blk_err      <= 1'b0;
        end else begin
            lk_rsp_valid <= lk_req;
            lk_hit       <= lk_req && m_hit;
            lk_pa        <= (lk_req && m_hit) ? ent_pa[m_idx] + m_off[PA_W-1:0] : '0;
            lk_attr      <= (lk_req && m_hit) ? ent_attr[m_idx] : '0;
            blk_err      <= (do_bpur && slot_bad) || (do_bins && bins_bad);
        end
    end

    assign busy = !idle;

    logic unused_bits;
    assign unused_bits = ^{op1_sh[63:PA_W], ins_low[VA_W-1:PA_W], m_off[VA_W-1:PA_W], pur_low};
endmodule

// File: rtl/range_tlb_chk.sv
`timescale 1ns/1ps
module range_tlb_chk #(
    parameter int N_SLOTS = 8,
    parameter int N_BLOCK = 2,
    parameter int SLOT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_req,
    input logic              lk_rsp_valid,
    input logic              lk_hit,
    input logic              busy,
    input logic              ins_req,
    input logic              purall_req,
    input logic              blk_pur_req,
    input logic              blk_ins_req,
    input logic              blk_err,
    input logic [SLOT_W-1:0] rr_ptr
);
    a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> lk_rsp_valid);

    a_r1_hit_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_rsp_valid);

    a_r13_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    a_r13_insert_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && ins_req && !purall_req && !blk_pur_req && !blk_ins_req) |=> busy);

    a_r9_err_source: assert property (@(posedge clk) disable iff (!rst_n)
        blk_err |-> $past(blk_ins_req || blk_pur_req));

    a_r10_err_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        blk_err |-> !busy);

    a_r6_rr_in_ordinary: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rr_ptr) >= N_BLOCK) && (int'(rr_ptr) < N_SLOTS));
endmodule

bind range_tlb range_tlb_chk #(
    .N_SLOTS(N_SLOTS),
    .N_BLOCK(N_BLOCK),
    .SLOT_W (SLOT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_req      (lk_req),
    .lk_rsp_valid(lk_rsp_valid),
    .lk_hit      (lk_hit),
    .busy        (busy),
    .ins_req     (ins_req),
    .purall_req  (purall_req),
    .blk_pur_req (blk_pur_req),
    .blk_ins_req (blk_ins_req),
    .blk_err     (blk_err),
    .rr_ptr      (rr_q)
);

// File: tb/sim_range_tlb.sv
`timescale 1ns/1ps
module sim_range_tlb;
    localparam int VA_W = 48;
    localparam int PA_W = 40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lk_req = 1'b0;
    logic [VA_W-1:0]   lk_va = '0;
    logic              lk_rsp_valid, lk_hit;
    logic [PA_W-1:0]   lk_pa;
    logic [41:0]       lk_attr;
    logic              ins_req = 1'b0;
    logic [63:0]       ins_op1 = '0, ins_op2 = '0;
    logic [VA_W-1:0]   ins_va = '0;
    logic              pur_req = 1'b0;
    logic [VA_W-1:0]   pur_addr = '0;
    logic              purall_req = 1'b0;
    logic              blk_ins_req = 1'b0, blk_pur_req = 1'b0;
    logic [2:0]        blk_slot = '0;
    logic [35:0]       blk_vpage = '0;
    logic [27:0]       blk_ppage = '0;
    logic [15:0]       blk_len = '0;
    logic [63:0]       blk_word = '0;
    logic              blk_err, busy;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    range_tlb u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_req(lk_req), .lk_va(lk_va), .lk_rsp_valid(lk_rsp_valid),
        .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_attr(lk_attr),
        .ins_req(ins_req), .ins_op1(ins_op1), .ins_op2(ins_op2), .ins_va(ins_va),
        .pur_req(pur_req), .pur_addr(pur_addr), .purall_req(purall_req),
        .blk_ins_req(blk_ins_req), .blk_pur_req(blk_pur_req), .blk_slot(blk_slot),
        .blk_vpage(blk_vpage), .blk_ppage(blk_ppage), .blk_len(blk_len),
        .blk_word(blk_word), .blk_err(blk_err), .busy(busy)
    );

    typedef struct {
        logic             hit;
        logic [PA_W-1:0]  pa;
        logic [41:0]      attr;
        string            tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t mon_e;

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_op2(input logic t, input logic d, input logic b,
                                           input logic [2:0] ty, input logic [1:0] l1,
                                           input logic [1:0] l2, input logic u,
                                           input logic [30:0] aid);
        logic [63:0] w;
        w = 64'h0;
        w[61] = t; w[60] = d; w[59] = b; w[58:56] = ty;
        w[55:54] = l1; w[53:52] = l2; w[51] = u; w[31:1] = aid;
        w[50] = 1'b1; w[0] = 1'b1;   // ignored bits set as noise
        return w;
    endfunction

    function automatic logic [41:0] mk_attr(input logic t, input logic d, input logic b,
                                            input logic [2:0] ty, input logic [1:0] l1,
                                            input logic [1:0] l2, input logic u,
                                            input logic [30:0] aid);
        return {t, d, b, ty, l1, l2, u, aid};
    endfunction

    // Monitor: pops the scoreboard when a response appears.
    always @(negedge clk) begin
        if (rst_n && lk_rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R1", "unexpected response", 64'd1, 64'd0);
            end else begin
                mon_e = exp_q.pop_front();
                check(mon_e.tag, "hit",  64'(lk_hit),  64'(mon_e.hit));
                check(mon_e.tag, "pa",   64'(lk_pa),   64'(mon_e.pa));
                check(mon_e.tag, "attr", 64'(lk_attr), 64'(mon_e.attr));
            end
        end
    end

    task automatic push_exp(input logic hit, input logic [PA_W-1:0] pa,
                            input logic [41:0] attr, input string tag);
        exp_t e;
        e.hit = hit; e.pa = hit ? pa : '0; e.attr = hit ? attr : '0; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic lookup(input logic [VA_W-1:0] va, input logic hit,
                          input logic [PA_W-1:0] pa, input logic [41:0] attr,
                          input string tag);
        lk_req = 1'b1; lk_va = va;
        push_exp(hit, pa, attr, tag);
        @(negedge clk);
        lk_req = 1'b0;
    endtask

    task automatic insert(input logic [63:0] op1, input logic [63:0] op2,
                          input logic [VA_W-1:0] va);
        ins_req = 1'b1; ins_op1 = op1; ins_op2 = op2; ins_va = va;
        @(negedge clk);
        ins_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic purge(input logic [VA_W-1:0] a);
        pur_req = 1'b1; pur_addr = a;
        @(negedge clk);
        pur_req = 1'b0;
    endtask

    task automatic purge_all();
        purall_req = 1'b1;
        @(negedge clk);
        purall_req = 1'b0;
    endtask

    task automatic blk_insert(input logic [2:0] slot, input logic [35:0] vp,
                              input logic [27:0] pp, input logic [15:0] len,
                              input logic [63:0] w, input logic exp_err, input string tag);
        blk_ins_req = 1'b1; blk_slot = slot; blk_vpage = vp;
        blk_ppage = pp; blk_len = len; blk_word = w;
        @(negedge clk);
        blk_ins_req = 1'b0;
        check(tag, "blk_err", 64'(blk_err), 64'(exp_err));
        @(negedge clk);
    endtask

    task automatic blk_purge(input logic [2:0] slot, input logic exp_err, input string tag);
        blk_pur_req = 1'b1; blk_slot = slot;
        @(negedge clk);
        blk_pur_req = 1'b0;
        check(tag, "blk_err", 64'(blk_err), 64'(exp_err));
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [41:0] a1, ablk, a0;
        a1   = mk_attr(1, 0, 1, 3'd5, 2'd2, 2'd1, 1, 31'h1234);
        ablk = mk_attr(0, 1, 0, 3'd3, 2'd3, 2'd0, 0, 31'h55);
        a0   = mk_attr(0, 0, 0, 3'd0, 2'd0, 2'd0, 0, 31'h0);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        check("R13", "busy after reset", 64'(busy), 64'd0);
        check("R9", "blk_err after reset", 64'(blk_err), 64'd0);
        check("R1", "rsp after reset", 64'(lk_rsp_valid), 64'd0);
        lookup(48'h0000_1234_5678, 0, '0, '0, "R1");

        // R2 R3 R4: one-page entry
        insert((64'hABCDE << 5), mk_op2(1, 0, 1, 3'd5, 2'd2, 2'd1, 1, 31'h1234), 48'h0000_1234_5678);
        lookup(48'h0000_1234_5678, 1, 40'hAB_CDE6_78, a1, "R4");
        lookup(48'h0000_1234_5FFF, 1, 40'hAB_CDEF_FF, a1, "R1");
        lookup(48'h0000_1234_6000, 0, '0, '0, "R2");
        lookup(48'h0000_1234_4FFF, 0, '0, '0, "R2");

        // R2 R3: 16 KB entry, both bases aligned down
        insert((64'h103 << 5) | 64'd1, 64'h0, 48'h0000_4000_7ABC);
        lookup(48'h0000_4000_7ABC, 1, 40'h00_0010_3ABC, a0, "R3");
        lookup(48'h0000_4000_4000, 1, 40'h00_0010_0000, a0, "R2");

        // R5: overlapping insert removes the 16 KB entry
        insert((64'h777 << 5), 64'h0, 48'h0000_4000_5000);
        lookup(48'h0000_4000_4000, 0, '0, '0, "R5");
        lookup(48'h0000_4000_5010, 1, 40'h00_0077_7010, a0, "R5");

        // R12: lookup coinciding with a purge sees old state
        lk_req = 1'b1; lk_va = 48'h0000_1234_5678;
        pur_req = 1'b1; pur_addr = 48'h0000_1234_5000;
        push_exp(1, 40'hAB_CDE6_78, a1, "R12");
        @(negedge clk);
        lk_req = 1'b0; pur_req = 1'b0;
        lookup(48'h0000_1234_5678, 0, '0, '0, "R7");

        // R7: size-coded purge
        purge(48'h0000_4000_4001);
        lookup(48'h0000_4000_5010, 0, '0, '0, "R7");

        // R9: block insert with forced T and D
        blk_insert(3'd0, 36'h80000, 28'h200, 16'd3, mk_op2(1, 0, 0, 3'd3, 2'd3, 2'd0, 0, 31'h55), 0, "R9");
        lookup(48'h0000_8000_2FFC, 1, 40'h00_0020_2FFC, ablk, "R9");
        lookup(48'h0000_8000_3000, 0, '0, '0, "R9");

        // R7: range purge keeps block slots
        purge(48'h0000_8000_1000);
        lookup(48'h0000_8000_1000, 1, 40'h00_0020_1000, ablk, "R7");

        // R8: purge-all keeps block slots
        insert((64'h5 << 5), 64'h0, 48'h0000_9000_0000);
        purge_all();
        lookup(48'h0000_9000_0000, 0, '0, '0, "R8");
        lookup(48'h0000_8000_0000, 1, 40'h00_0020_0000, ablk, "R8");

        // R9 R10: rejected block commands
        blk_insert(3'd2, 36'hD0000, 28'h1, 16'd1, 64'h0, 1, "R9");
        blk_insert(3'd1, 36'hD0000, 28'h1, 16'd0, 64'h0, 1, "R9");
        blk_purge(3'd7, 1, "R10");
        lookup(48'h0000_D000_0000, 0, '0, '0, "R9");
        lookup(48'h0000_8000_0000, 1, 40'h00_0020_0000, ablk, "R10");

        // R11: block slot wins over an overlapping ordinary entry
        blk_insert(3'd1, 36'hA0000, 28'h300, 16'd4, 64'h0, 0, "R11");
        insert((64'h999 << 5), 64'h0, 48'h0000_A000_1000);
        lookup(48'h0000_A000_1234, 1, 40'h00_0030_1234, mk_attr(0, 1, 0, 0, 0, 0, 0, 0), "R11");
        blk_purge(3'd1, 0, "R10");
        lookup(48'h0000_A000_1234, 1, 40'h00_0099_9234, a0, "R10");

        // R13: purge-all during busy is ignored
        ins_req = 1'b1; ins_op1 = (64'h11 << 5); ins_op2 = 64'h0; ins_va = 48'h0000_B000_0000;
        @(negedge clk);
        ins_req = 1'b0; purall_req = 1'b1;
        check("R13", "busy in write cycle", 64'(busy), 64'd1);
        @(negedge clk);
        purall_req = 1'b0;
        lookup(48'h0000_B000_0000, 1, 40'h00_0001_1000, a0, "R13");
        lookup(48'h0000_A000_1234, 1, 40'h00_0099_9234, a0, "R13");

        // R13: insert outranks a coinciding range purge
        ins_req = 1'b1; ins_op1 = (64'h22 << 5); ins_va = 48'h0000_B000_2000;
        pur_req = 1'b1; pur_addr = 48'h0000_B000_0000;
        @(negedge clk);
        ins_req = 1'b0; pur_req = 1'b0;
        @(negedge clk);
        lookup(48'h0000_B000_0000, 1, 40'h00_0001_1000, a0, "R13");
        lookup(48'h0000_B000_2000, 1, 40'h00_0002_2000, a0, "R13");

        // R6: free slots first, then round robin
        purge_all();
        for (int k = 0; k < 7; k++) begin
            insert((64'(8'h40 + k) << 5), 64'h0, 48'h0000_C000_0000 + 48'(k) * 48'h1000);
        end
        lookup(48'h0000_C000_0000, 0, '0, '0, "R6");
        lookup(48'h0000_C000_6000, 1, 40'h00_0004_6000, a0, "R6");
        lookup(48'h0000_C000_1000, 1, 40'h00_0004_1000, a0, "R6");
        insert((64'h47 << 5), 64'h0, 48'h0000_C000_7000);
        lookup(48'h0000_C000_1000, 0, '0, '0, "R6");
        lookup(48'h0000_C000_7000, 1, 40'h00_0004_7000, a0, "R6");
        purge(48'h0000_C000_3000);
        insert((64'h48 << 5), 64'h0, 48'h0000_C000_8000);
        lookup(48'h0000_C000_2000, 1, 40'h00_0004_2000, a0, "R6");
        lookup(48'h0000_C000_8000, 1, 40'h00_0004_8000, a0, "R6");

        repeat (3) @(negedge clk);
        check("R1", "pending responses", 64'(exp_q.size()), 64'd0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule